// File: doc/BRIEF.md
# Battery Pack Fault Protection Controller

This block owns the charge-enable and discharge-enable outputs of a four-cell series pack. Comparators outside the block supply raw threshold flags: overvoltage and undervoltage for each cell, plus discharge overcurrent, short circuit, over-temperature and cold temperature. The block sees each condition only through one of these flags. Each of the six fault classes has its own qualification delay. The delay is counted in ticks of an external one-microsecond strobe. A fault trips only when its raw flag has been sampled high on that many consecutive ticks.

When a fault trips, three things happen at the same clock edge. A sticky status flag is latched. The enables tied to that fault class are dropped. A one-cycle alert pulse is raised in the following cycle. A host clears flags through a write-one-to-clear port. It restores both enables with an explicit enable request, and that request is honoured only when no fault flag is set. A status byte reports the grouped fault flags, the two enables and a load-connected indication supplied from outside.

Top module: `pack_guard`

## Requirements
- R1: After reset, `chg_en`, `dsg_en` and `alert` are low and all fault flags are clear, so `status` equals `{1'b0, load_on, 6'b0}`.
- R2: A fault trips only after its raw flag has been sampled high on `DLY` clock edges where `tick_us` is high. Edges with `tick_us` low neither advance nor restart the count. Default delays: overvoltage 2 s, undervoltage 4 s, overcurrent 20 ms, short circuit 70 us.
- R3: If a raw flag goes low before its delay expires, that fault's count restarts from zero, so separate short bursts never add up to a trip.
- R4: The overvoltage fault is raised by any of the four bits of `ov_cell`, and the undervoltage fault by any of the four bits of `uv_cell`.
- R5: An overvoltage trip, an over-temperature trip and a cold-temperature trip each clear `chg_en` at the trip edge. Overvoltage and cold-temperature trips leave `dsg_en` unchanged.
- R6: An undervoltage trip, an overcurrent trip and a short-circuit trip each clear `dsg_en` and leave `chg_en` unchanged. An over-temperature trip clears `dsg_en` as well.
- R7: Status bit layout: bit0 overvoltage, bit1 undervoltage, bit2 overcurrent OR short circuit, bit3 over-temperature OR cold temperature, bit4 `chg_en`, bit5 `dsg_en`, bit6 `load_on`, bit7 constant 0.
- R8: Fault flags stay set after their raw flags go low. A cycle with `clr_we` high clears the flags whose status bit is 1 in `clr_data`: bit2 clears both current faults and bit3 clears both temperature faults. Bits written as 0 are untouched. A trip in the same cycle as its clear leaves the flag set.
- R9: `alert` is high for exactly the one cycle that follows an edge at which at least one fault flag went from clear to set. A trip on an already-set flag gives no pulse.
- R10: A cycle with `en_req` high sets both enables at the next edge only when no fault flag is set and no trip occurs in that cycle. Otherwise the request has no effect, including when it coincides with a clearing write.
- R11: A raw flag that stays high after its trip keeps the fault qualified. Each further tick re-sets the flag, so a clearing write cannot remove it while the condition persists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-microsecond time-base strobe |
| ov_cell | input | NCELL | Per-cell overvoltage compare flags |
| uv_cell | input | NCELL | Per-cell undervoltage compare flags |
| ocd_cmp | input | 1 | Discharge overcurrent compare flag |
| scd_cmp | input | 1 | Short-circuit compare flag |
| hot_cmp | input | 1 | Over-temperature compare flag |
| cold_cmp | input | 1 | Cold-temperature compare flag |
| load_on | input | 1 | Load-connected indication, reported in the status byte |
| clr_we | input | 1 | Write strobe for the write-one-to-clear port |
| clr_data | input | 8 | Clear mask in status bit positions |
| en_req | input | 1 | Host request to turn on both enables |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| alert | output | 1 | One-cycle pulse when a fault flag is newly set |
| status | output | 8 | Fault flags, enables and load indication |

## Verification
A raw flag raised before edge 1, with `tick_us` high on every edge, is due to show in `status`, the enables and `alert` right after edge `DLY`. The flag must still be absent after edge `DLY-1`, so the bench checks both points. `alert` is checked high after that edge and low one cycle later. Clearing writes and enable requests act at the single edge that samples them, and `status` follows the registers combinationally. The bench therefore drives every input and samples every output on the falling edge, counting rising edges from the stimulus exactly.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int NF     = 6;
  localparam int F_OV   = 0;
  localparam int F_UV   = 1;
  localparam int F_OCD  = 2;
  localparam int F_SCD  = 3;
  localparam int F_HOT  = 4;
  localparam int F_COLD = 5;

  typedef logic [NF-1:0] fvec_t;

  // fault classes that take away the charge path
  function automatic logic f_chg_drop(input fvec_t t);
    return t[F_OV] | t[F_HOT] | t[F_COLD];
  endfunction

  // fault classes that take away the discharge path
  function automatic logic f_dsg_drop(input fvec_t t);
    return t[F_UV] | t[F_OCD] | t[F_SCD] | t[F_HOT];
  endfunction

  // status-bit positions mapped onto the internal fault flags
  function automatic fvec_t f_clr_mask(input logic [7:0] d);
    fvec_t m;
    m[F_OV]   = d[0];
    m[F_UV]   = d[1];
    m[F_OCD]  = d[2];
    m[F_SCD]  = d[2];
    m[F_HOT]  = d[3];
    m[F_COLD] = d[3];
    return m;
  endfunction

  function automatic logic [7:0] f_status(input fvec_t f, input logic c,
                                          input logic d, input logic l);
    return {1'b0, l, d, c, f[F_HOT] | f[F_COLD], f[F_OCD] | f[F_SCD],
            f[F_UV], f[F_OV]};
  endfunction

  function automatic int unsigned f_umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pg_qual.sv
module pg_qual #(
  parameter int unsigned DLY = 1,
  parameter int          W   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic trip
);
  localparam logic [W-1:0] LAST = W'(DLY - 1);

  logic [W-1:0] cnt;

  // qualified on the DLY-th ticked edge with the condition present
  assign trip = raw & tick & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (!raw)                 cnt <= '0;
    else if (tick && cnt != LAST)  cnt <= cnt + 1'b1;
  end

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !tick) |=> $stable(cnt));
  a_r3_restart_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> (cnt == '0));
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/pg_flags.sv
module pg_flags
  import pg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fvec_t      trip,
  input  logic       clr_we,
  input  logic [7:0] clr_data,
  output fvec_t      flags,
  output logic       alert
);
  fvec_t clr_m;
  fvec_t newly;
  fvec_t nxt;

  assign clr_m = clr_we ? f_clr_mask(clr_data) : '0;
  assign newly = trip & ~flags;
  assign nxt   = (flags & ~clr_m) | trip;   // a trip outranks a clear

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      alert <= 1'b0;
    end else begin
      flags <= nxt;
      alert <= |newly;
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_chk
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr_m[i]) |=> flags[i]);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      trip[i] |=> flags[i]);
  end

  a_r9_alert_cause: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> (|(flags & ~$past(flags))));
endmodule

// File: rtl/pg_switch.sv
module pg_switch
  import pg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  fvec_t trip,
  input  fvec_t flags,
  input  logic  en_req,
  output logic  chg_en,
  output logic  dsg_en
);
  logic restore;
  logic chg_kill;
  logic dsg_kill;

  assign restore  = en_req && (flags == '0) && (trip == '0);
  assign chg_kill = f_chg_drop(trip);
  assign dsg_kill = f_dsg_drop(trip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chg_en <= 1'b0;
      dsg_en <= 1'b0;
    end else begin
      if (chg_kill)     chg_en <= 1'b0;
      else if (restore) chg_en <= 1'b1;
      if (dsg_kill)     dsg_en <= 1'b0;
      else if (restore) dsg_en <= 1'b1;
    end
  end

  a_r5_chg_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (trip[F_OV] || trip[F_HOT] || trip[F_COLD]) |=> !chg_en);
  a_r6_dsg_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (trip[F_UV] || trip[F_OCD] || trip[F_SCD] || trip[F_HOT]) |=> !dsg_en);
  a_r10_chg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flags) && !chg_en) |=> !chg_en);
  a_r10_dsg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flags) && !dsg_en) |=> !dsg_en);
endmodule

// File: rtl/pack_guard.sv
module pack_guard
  import pg_pkg::*;
#(
  parameter int          NCELL    = 4,
  parameter int unsigned OV_DLY   = 2_000_000,
  parameter int unsigned UV_DLY   = 4_000_000,
  parameter int unsigned OCD_DLY  = 20_000,
  parameter int unsigned SCD_DLY  = 70,
  parameter int unsigned HOT_DLY  = 1_000_000,
  parameter int unsigned COLD_DLY = 1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_us,
  input  logic [NCELL-1:0] ov_cell,
  input  logic [NCELL-1:0] uv_cell,
  input  logic             ocd_cmp,
  input  logic             scd_cmp,
  input  logic             hot_cmp,
  input  logic             cold_cmp,
  input  logic             load_on,
  input  logic             clr_we,
  input  logic [7:0]       clr_data,
  input  logic             en_req,
  output logic             chg_en,
  output logic             dsg_en,
  output logic             alert,
  output logic [7:0]       status
);
  localparam int unsigned DLY_TAB [NF] = '{OV_DLY, UV_DLY, OCD_DLY, SCD_DLY,
                                           HOT_DLY, COLD_DLY};
  localparam int unsigned DMAX = f_umax(f_umax(f_umax(OV_DLY, UV_DLY),
                                               f_umax(OCD_DLY, SCD_DLY)),
                                        f_umax(HOT_DLY, COLD_DLY));
  localparam int CNT_W = $clog2(DMAX + 1);

  fvec_t raw;
  fvec_t trip;
  fvec_t flags;

  assign raw[F_OV]   = |ov_cell;
  assign raw[F_UV]   = |uv_cell;
  assign raw[F_OCD]  = ocd_cmp;
  assign raw[F_SCD]  = scd_cmp;
  assign raw[F_HOT]  = hot_cmp;
  assign raw[F_COLD] = cold_cmp;

  for (genvar g = 0; g < NF; g++) begin : g_qual
    pg_qual #(.DLY(DLY_TAB[g]), .W(CNT_W)) u_q (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_us),
      .raw  (raw[g]),
      .trip (trip[g])
    );
  end

  pg_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip    (trip),
    .clr_we  (clr_we),
    .clr_data(clr_data),
    .flags   (flags),
    .alert   (alert)
  );

  pg_switch u_sw (
    .clk   (clk),
    .rst_n (rst_n),
    .trip  (trip),
    .flags (flags),
    .en_req(en_req),
    .chg_en(chg_en),
    .dsg_en(dsg_en)
  );

  assign status = f_status(flags, chg_en, dsg_en, load_on);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!chg_en && !dsg_en && !alert && status[3:0] == 4'h0));
  a_r7_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == 1'b0);
endmodule

// File: tb/sim_pack_guard.sv
`timescale 1ns/1ps
module sim_pack_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b1;
  logic [3:0] ov_cell = '0;
  logic [3:0] uv_cell = '0;
  logic       ocd = 1'b0, scd = 1'b0, hot = 1'b0, cold = 1'b0;
  logic       load_on = 1'b1;
  logic       clr_we = 1'b0;
  logic [7:0] clr_data = '0;
  logic       en_req = 1'b0;
  logic       chg_en, dsg_en, alert;
  logic [7:0] status;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  pack_guard #(.NCELL(4), .OV_DLY(8), .UV_DLY(10), .OCD_DLY(5), .SCD_DLY(3),
               .HOT_DLY(6), .COLD_DLY(4)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .ov_cell(ov_cell),
    .uv_cell(uv_cell), .ocd_cmp(ocd), .scd_cmp(scd), .hot_cmp(hot),
    .cold_cmp(cold), .load_on(load_on), .clr_we(clr_we), .clr_data(clr_data),
    .en_req(en_req), .chg_en(chg_en), .dsg_en(dsg_en), .alert(alert),
    .status(status)
  );

  typedef struct packed {
    logic [2:0] src;
    logic [7:0] dly;
    logic       chg;
    logic       dsg;
    logic [7:0] stat;
  } row_t;

  // src: 0 ov cell2, 1 uv cell0, 2 ocd, 3 scd, 4 hot, 5 cold, 6 ov cell3, 7 uv cell3
  localparam row_t TAB [8] = '{
    '{3'd0, 8'd8,  1'b0, 1'b1, 8'h21},
    '{3'd1, 8'd10, 1'b1, 1'b0, 8'h12},
    '{3'd2, 8'd5,  1'b1, 1'b0, 8'h14},
    '{3'd3, 8'd3,  1'b1, 1'b0, 8'h14},
    '{3'd4, 8'd6,  1'b0, 1'b0, 8'h08},
    '{3'd5, 8'd4,  1'b0, 1'b1, 8'h28},
    '{3'd6, 8'd8,  1'b0, 1'b1, 8'h21},
    '{3'd7, 8'd10, 1'b1, 1'b0, 8'h12}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_src(input logic [2:0] s, input logic v);
    case (s)
      3'd0: ov_cell[2] = v;
      3'd1: uv_cell[0] = v;
      3'd2: ocd = v;
      3'd3: scd = v;
      3'd4: hot = v;
      3'd5: cold = v;
      3'd6: ov_cell[3] = v;
      default: uv_cell[3] = v;
    endcase
  endtask

  task automatic w1c(input logic [7:0] d);
    clr_we = 1'b1; clr_data = d;
    cyc(1);
    clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic enreq();
    en_req = 1'b1;
    cyc(1);
    en_req = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state, load bit reflected (R7)
    chk("R1 chg_en", chg_en, 0);
    chk("R1 dsg_en", dsg_en, 0);
    chk("R1 alert", alert, 0);
    chk("R1 status", status, 8'h40);
    load_on = 1'b0;
    cyc(1);
    chk("R7 load bit", status, 8'h00);
    enreq();
    chk("R10 enables on", status, 8'h30);

    for (int i = 0; i < 8; i++) begin
      drive_src(TAB[i].src, 1'b1);
      cyc(int'(TAB[i].dly) - 1);
      chk("R2 not yet", status & 8'h0F, 0);
      chk("R2 no early alert", alert, 0);
      cyc(1);
      chk((TAB[i].src >= 3'd6) ? "R4 cell status" : "R7 status", status, TAB[i].stat);
      chk("R5 chg_en", chg_en, TAB[i].chg);
      chk("R6 dsg_en", dsg_en, TAB[i].dsg);
      chk("R9 alert", alert, 1);
      drive_src(TAB[i].src, 1'b0);
      cyc(1);
      chk("R9 alert one cycle", alert, 0);
      cyc(2);
      chk("R8 sticky", status, TAB[i].stat);
      w1c(8'hFF);
      chk("R8 cleared", status & 8'h0F, 0);
      enreq();
      chk("R10 restored", {chg_en, dsg_en}, 2'b11);
    end

    // R3 glitches do not accumulate
    scd = 1; cyc(2); scd = 0; cyc(1); scd = 1; cyc(2); scd = 0; cyc(1);
    chk("R3 glitch no trip", status, 8'h30);
    chk("R3 no alert", alert, 0);

    // R2 cycles without tick do not count
    tick_us = 0; ocd = 1; cyc(20);
    chk("R2 no tick", status, 8'h30);
    tick_us = 1; cyc(4);
    chk("R2 four ticks", status, 8'h30);
    cyc(1);
    chk("R2 fifth tick trips", status, 8'h14);
    ocd = 0; w1c(8'hFF); enreq();
    chk("R10 back on", status, 8'h30);

    // R8 partial clear, R10 blocked while flag set
    ov_cell[0] = 1; uv_cell[1] = 1; cyc(10);
    chk("R8 both set", status, 8'h03);
    ov_cell[0] = 0; uv_cell[1] = 0;
    w1c(8'h01);
    chk("R8 partial clear", status, 8'h02);
    enreq();
    chk("R10 blocked chg", chg_en, 0);
    chk("R10 blocked dsg", dsg_en, 0);
    w1c(8'h02);
    chk("R8 second clear", status, 8'h00);

    // R11 persistent fault re-latches, clear loses to trip
    hot = 1; cyc(6);
    chk("R11 hot trip", status, 8'h08);
    cyc(1);
    chk("R9 no repeat alert", alert, 0);
    w1c(8'h08);
    chk("R11 still set", status, 8'h08);
    chk("R9 no alert on retrip", alert, 0);
    hot = 0; cyc(1);
    // R10 request in the same cycle as the clearing write is ignored
    clr_we = 1; clr_data = 8'hFF; en_req = 1;
    cyc(1);
    clr_we = 0; clr_data = '0; en_req = 0;
    chk("R10 same-cycle ignored", status, 8'h00);
    enreq();
    chk("R10 final restore", status, 8'h30);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule